// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking translation tables held in memory. A request carries the virtual address and whether the access is a write. The walker first reads a root descriptor out of a per-context table, then descends through up to three table levels. It stops at the first leaf entry, which may map a 16 MB, 256 KB or 4 KB page. All table reads and the single optional write go through one word-wide memory port that allows one access at a time.

When the leaf's referenced bit is clear, or the access is a write and the leaf's dirty bit is clear, the walker sets the needed bits and writes the entry back to the address it was read from. The walk then ends. With translation disabled, the walker answers at once with the virtual address as the physical address and touches no memory. Each walk ends with a single-cycle completion pulse. That pulse carries the fault status, the level reached, the final entry, its memory address and the physical address. Permission checks and result caching belong to the caller.

Top module: `ptw_walker`

## Requirements
- R1: With `ctl_enable` low at acceptance, the walk completes with no fault, `walk_level` 0, `leaf_entry` and `leaf_addr` 0, `phys_addr` equal to the zero-extended virtual address, and no memory access.
- R2: Bits [1:0] of every fetched word select its kind: 0 invalid, 1 pointer to the next table, 2 leaf, 3 reserved.
- R3: The first read is at `(ctx_table_ptr << 4) + (ctx_id << 4)`, truncated to 32 bits.
- R4: A pointer word W gives a next-table base of `{W[27:2], 6'b0}`. The next read is at that base plus 4 times the index, where the index is virtual-address bits [31:24] for table 1, [23:18] for table 2 and [17:12] for table 3.
- R5: A leaf word L read from table 1, 2 or 3 ends the walk with `walk_level` 1, 2 or 3. `phys_addr` (36 bits) is `{L[31:8], 12'b0}` plus the low 24, 18 or 12 virtual-address bits.
- R6: An invalid word ends the walk with `fault_code` 1. A reserved word at any level, a leaf in the context table, or a pointer in table 3 ends it with `fault_code` 2. In both cases `fault_valid` is 1, and `walk_level` (0 for the context table) and `leaf_addr` give where the word was read, and `leaf_entry` gives the word itself.
- R7: A leaf with referenced bit 5 clear, or a write request with dirty bit 6 clear, is written back once to its own address, with bit 5 set and bit 6 also set for a write. `leaf_entry` reports the updated word.
- R8: A leaf that needs neither bit update causes no memory write and is reported unchanged.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R10: `done` is high for exactly one cycle per accepted request, and `req_ready` is high only while the walker is idle.
- R11: After reset, `req_ready` is 1 and `done` and `mem_valid` are 0.
- R12: The number of table reads equals the number of levels visited: one per level from the context table to the terminating word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| ctl_enable | input | 1 | Translation enable; low selects bypass |
| ctx_table_ptr | input | 32 | Context table pointer |
| ctx_id | input | CTX_W | Context number |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_addr | output | 32 | Byte address of the word |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 1 invalid, 2 bad type |
| walk_level | output | 2 | Level at which the walk ended |
| leaf_entry | output | 32 | Final entry (updated if written back) |
| leaf_addr | output | 32 | Address of the final entry |
| phys_addr | output | 36 | Translated physical address |

## Verification
The bench builds the walker with a 4-bit context number and the default referenced and dirty bit positions. With that width, sixteen context slots and two context-table pointers exercise the root address sum of R3. All tables fit in a 16 KB memory model, so each fetch address of R4 can be checked against a bench model of the walk. A random-delay ready line stretches every memory access. This covers the hold rule of R9, and write requests with forced referenced and dirty patterns cover each branch of the write-back decision.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   localparam int WORD_W   = 32;
   localparam int PA_W     = 36;
   localparam int PG_SHIFT = 12;
   localparam int N_TBL    = 3;

   // virtual-address index field per table level (1..3)
   localparam int T1_HI = 31;
   localparam int T1_LO = 24;
   localparam int T2_HI = 23;
   localparam int T2_LO = 18;
   localparam int T3_HI = 17;
   localparam int T3_LO = 12;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_TABLE   = 2'd1,
      ET_LEAF    = 2'd2,
      ET_RSVD    = 2'd3
   } ent_type_e;

   typedef enum logic [1:0] {
      FC_NONE    = 2'd0,
      FC_INVALID = 2'd1,
      FC_BADTYPE = 2'd2
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WBACK,
      ST_DONE
   } walk_state_e;

   typedef enum logic [1:0] {
      STEP_DESCEND,
      STEP_LEAF,
      STEP_FAULT
   } step_e;

endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr
   import ptw_pkg::*;
#(
   parameter int CTX_W = 8
) (
   input  logic [1:0]        lvl,
   input  logic [WORD_W-1:0] va,
   input  logic [WORD_W-1:0] ctx_ptr,
   input  logic [CTX_W-1:0]  ctx,
   input  logic [WORD_W-1:0] base,
   output logic [WORD_W-1:0] addr
);

   logic [WORD_W-1:0] idx_off [N_TBL];

   for (genvar g = 0; g < N_TBL; g++) begin : g_idx
      localparam int HI = (g == 0) ? T1_HI : ((g == 1) ? T2_HI : T3_HI);
      localparam int LO = (g == 0) ? T1_LO : ((g == 1) ? T2_LO : T3_LO);
      assign idx_off[g] = WORD_W'(va[HI:LO]) << 2;
   end

   logic [WORD_W-1:0] root_addr;
   assign root_addr = (ctx_ptr << 4) + (WORD_W'(ctx) << 4);

   always_comb begin
      case (lvl)
         2'd0:    addr = root_addr;
         2'd1:    addr = base + idx_off[0];
         2'd2:    addr = base + idx_off[1];
         default: addr = base + idx_off[2];
      endcase
   end

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
   import ptw_pkg::*;
#(
   parameter int ACC_BIT = 5,
   parameter int MOD_BIT = 6
) (
   input  logic [WORD_W-1:0] entry,
   input  logic [1:0]        lvl,
   input  logic              is_write,
   input  logic [WORD_W-1:0] va,
   output step_e             step,
   output fault_e            code,
   output logic              need_wb,
   output logic [WORD_W-1:0] upd_entry,
   output logic [PA_W-1:0]   phys
);

   localparam logic [WORD_W-1:0] OFF1_MSK = (WORD_W'(1) << T1_LO) - 1;
   localparam logic [WORD_W-1:0] OFF2_MSK = (WORD_W'(1) << T2_LO) - 1;
   localparam logic [WORD_W-1:0] OFF3_MSK = (WORD_W'(1) << T3_LO) - 1;

   ent_type_e etype;
   assign etype = ent_type_e'(entry[1:0]);

   always_comb begin
      step = STEP_FAULT;
      code = FC_BADTYPE;
      case (etype)
         ET_INVALID: code = FC_INVALID;
         ET_TABLE: if (lvl != 2'd3) begin
            step = STEP_DESCEND;
            code = FC_NONE;
         end
         ET_LEAF: if (lvl != 2'd0) begin
            step = STEP_LEAF;
            code = FC_NONE;
         end
         default: ;
      endcase
   end

   assign need_wb = !entry[ACC_BIT] || (is_write && !entry[MOD_BIT]);

   always_comb begin
      upd_entry          = entry;
      upd_entry[ACC_BIT] = 1'b1;
      if (is_write) upd_entry[MOD_BIT] = 1'b1;
   end

   logic [WORD_W-1:0] off;
   always_comb begin
      case (lvl)
         2'd1:    off = va & OFF1_MSK;
         2'd2:    off = va & OFF2_MSK;
         default: off = va & OFF3_MSK;
      endcase
   end

   assign phys = {entry[WORD_W-1:8], PG_SHIFT'(0)} + PA_W'(off);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int CTX_W   = 8,
   parameter int ACC_BIT = 5,
   parameter int MOD_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_vaddr,
   input  logic              req_write,
   input  logic              ctl_enable,
   input  logic [31:0]       ctx_table_ptr,
   input  logic [CTX_W-1:0]  ctx_id,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [31:0]       mem_addr,
   output logic              mem_we,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              done,
   output logic              fault_valid,
   output logic [1:0]        fault_code,
   output logic [1:0]        walk_level,
   output logic [31:0]       leaf_entry,
   output logic [31:0]       leaf_addr,
   output logic [35:0]       phys_addr
);

   if (CTX_W < 1 || CTX_W > 28) begin : g_bad_ctx
      $error("ptw_walker: CTX_W out of range");
   end
   if (ACC_BIT < 2 || ACC_BIT > 7 || MOD_BIT < 2 || MOD_BIT > 7 || ACC_BIT == MOD_BIT) begin : g_bad_bits
      $error("ptw_walker: status bit positions must be distinct and within 7:2");
   end

   walk_state_e       st;
   logic [1:0]        lvl_q;
   logic [WORD_W-1:0] va_q, ctxp_q, base_q, leaf_q, laddr_q;
   logic [CTX_W-1:0]  ctx_q;
   logic              wr_q;
   fault_e            fault_q;
   logic [PA_W-1:0]   phys_q;

   logic [WORD_W-1:0] cur_addr;
   step_e             step;
   fault_e            step_code;
   logic              need_wb;
   logic [WORD_W-1:0] upd_entry;
   logic [PA_W-1:0]   step_phys;

   ptw_fetch_addr #(.CTX_W(CTX_W)) u_addr (
      .lvl     (lvl_q),
      .va      (va_q),
      .ctx_ptr (ctxp_q),
      .ctx     (ctx_q),
      .base    (base_q),
      .addr    (cur_addr)
   );

   ptw_entry_check #(.ACC_BIT(ACC_BIT), .MOD_BIT(MOD_BIT)) u_chk (
      .entry     (mem_rdata),
      .lvl       (lvl_q),
      .is_write  (wr_q),
      .va        (va_q),
      .step      (step),
      .code      (step_code),
      .need_wb   (need_wb),
      .upd_entry (upd_entry),
      .phys      (step_phys)
   );

   assign req_ready   = (st == ST_IDLE);
   assign mem_valid   = (st == ST_FETCH) || (st == ST_WBACK);
   assign mem_we      = (st == ST_WBACK);
   assign mem_addr    = (st == ST_WBACK) ? laddr_q : cur_addr;
   assign mem_wdata   = leaf_q;
   assign done        = (st == ST_DONE);
   assign fault_valid = (fault_q != FC_NONE);
   assign fault_code  = fault_q;
   assign walk_level  = lvl_q;
   assign leaf_entry  = leaf_q;
   assign leaf_addr   = laddr_q;
   assign phys_addr   = phys_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         lvl_q   <= '0;
         va_q    <= '0;
         ctxp_q  <= '0;
         ctx_q   <= '0;
         wr_q    <= 1'b0;
         base_q  <= '0;
         leaf_q  <= '0;
         laddr_q <= '0;
         fault_q <= FC_NONE;
         phys_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               ctxp_q  <= ctx_table_ptr;
               ctx_q   <= ctx_id;
               lvl_q   <= 2'd0;
               fault_q <= FC_NONE;
               if (ctl_enable) begin
                  st <= ST_FETCH;
               end else begin
                  leaf_q  <= '0;
                  laddr_q <= '0;
                  phys_q  <= PA_W'(req_vaddr);
                  st      <= ST_DONE;
               end
            end
            ST_FETCH: if (mem_ready) begin
               case (step)
                  STEP_DESCEND: begin
                     base_q <= {mem_rdata[27:2], 6'b0};
                     lvl_q  <= lvl_q + 2'd1;
                  end
                  STEP_LEAF: begin
                     leaf_q  <= need_wb ? upd_entry : mem_rdata;
                     laddr_q <= cur_addr;
                     phys_q  <= step_phys;
                     st      <= need_wb ? ST_WBACK : ST_DONE;
                  end
                  default: begin
                     fault_q <= step_code;
                     leaf_q  <= mem_rdata;
                     laddr_q <= cur_addr;
                     phys_q  <= '0;
                     st      <= ST_DONE;
                  end
               endcase
            end
            ST_WBACK: if (mem_ready) st <= ST_DONE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || done) |-> !req_ready);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R7
   wb_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we) |-> (mem_wdata[ACC_BIT] && mem_wdata[1:0] == 2'd2 && (mem_wdata[MOD_BIT] || !wr_q)));

   // R1
   bypass_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !ctl_enable) |=> (done && !mem_valid));

   // R5
   leaf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault_valid && walk_level != 2'd0) |-> (leaf_entry[1:0] == 2'd2 && leaf_entry[ACC_BIT]));

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

   localparam int CTX_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [31:0]       req_vaddr = '0;
   logic              req_write = 1'b0;
   logic              ctl_enable = 1'b0;
   logic [31:0]       ctx_table_ptr = '0;
   logic [CTX_W-1:0]  ctx_id = '0;
   logic              mem_valid;
   logic              mem_ready = 1'b0;
   logic [31:0]       mem_addr;
   logic              mem_we;
   logic [31:0]       mem_wdata;
   logic [31:0]       mem_rdata;
   logic              done;
   logic              fault_valid;
   logic [1:0]        fault_code;
   logic [1:0]        walk_level;
   logic [31:0]       leaf_entry;
   logic [31:0]       leaf_addr;
   logic [35:0]       phys_addr;

   always #10 clk = ~clk;

   ptw_walker #(.CTX_W(CTX_W)) u_ptw_walker (
      .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write,
      .ctl_enable, .ctx_table_ptr, .ctx_id, .mem_valid, .mem_ready,
      .mem_addr, .mem_we, .mem_wdata, .mem_rdata, .done, .fault_valid,
      .fault_code, .walk_level, .leaf_entry, .leaf_addr, .phys_addr
   );

   logic [31:0] mem [4096];
   assign mem_rdata = mem[mem_addr[13:2]];

   int          rd_cnt = 0, wr_cnt = 0, oob_cnt = 0, hold_err = 0;
   logic [31:0] wb_addr_seen = '0, wb_data_seen = '0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;

   always @(posedge clk) begin
      if (prev_stall && (!mem_valid || mem_addr != prev_addr)) hold_err <= hold_err + 1;
      prev_stall <= mem_valid && !mem_ready;
      prev_addr  <= mem_addr;
      if (mem_valid && mem_ready) begin
         if (mem_addr >= 32'h4000) oob_cnt <= oob_cnt + 1;
         if (mem_we) begin
            wr_cnt       <= wr_cnt + 1;
            wb_addr_seen <= mem_addr;
            wb_data_seen <= mem_wdata;
         end else begin
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   always @(negedge clk) mem_ready <= ($urandom % 10) < 6;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] idx_of(input logic [31:0] va, input int lv);
      case (lv)
         1:       return 32'(va[31:24]);
         2:       return 32'(va[23:18]);
         default: return 32'(va[17:12]);
      endcase
   endfunction

   // Writes a walk into memory; ft[l] < 0 picks the type at level l at random
   task automatic build(input logic [31:0] va, input int ctx, input logic [31:0] ctxp,
                        input int ft [4], input int rm);
      logic [31:0] a;
      logic [31:0] e;
      a = (ctxp << 4) + (32'(ctx) << 4);
      for (int l = 0; l < 4; l++) begin
         int r = int'($urandom % 8);
         int t = ft[l];
         if (t < 0) begin
            if (l < 3) t = (r < 4) ? 1 : (r < 6) ? 2 : (r == 6) ? 0 : 3;
            else       t = (r < 5) ? 2 : (r == 5) ? 0 : (r == 6) ? 1 : 3;
         end
         if (t == 1 && l < 3) begin
            logic [31:0] nb = 32'h1000 * 32'(l + 1);
            mem[a[13:2]] = (nb >> 4) | 32'h1;
            a = nb + (idx_of(va, l + 1) << 2);
         end else begin
            e = $urandom;
            e[1:0] = 2'(t);
            if (rm >= 0) begin
               e[5] = rm[0];
               e[6] = rm[1];
            end
            mem[a[13:2]] = e;
            break;
         end
      end
   endtask

   // Reference walk over the bench memory, built from the requirements
   task automatic model(input logic [31:0] va, input bit wr, input bit en, input int ctx,
                        input logic [31:0] ctxp, output logic [1:0] f, output logic [1:0] lv,
                        output logic [31:0] leaf, output logic [31:0] la, output logic [35:0] pa,
                        output int nrd, output int nwb);
      logic [31:0] a, e, off;
      f = 2'd0; lv = 2'd0; leaf = '0; la = '0; pa = 36'(va); nrd = 0; nwb = 0;
      if (!en) return;
      pa = '0;
      a = (ctxp << 4) + (32'(ctx) << 4);
      for (int l = 0; l < 4; l++) begin
         e = mem[a[13:2]];
         nrd++;
         lv = 2'(l);
         la = a;
         leaf = e;
         if (e[1:0] == 2'd0) begin
            f = 2'd1;
            return;
         end
         if (e[1:0] == 2'd3 || (e[1:0] == 2'd2 && l == 0) || (e[1:0] == 2'd1 && l == 3)) begin
            f = 2'd2;
            return;
         end
         if (e[1:0] == 2'd1) begin
            a = {e[27:2], 6'b0} + (idx_of(va, l + 1) << 2);
         end else begin
            off = (l == 1) ? (va & 32'hFF_FFFF) : (l == 2) ? (va & 32'h3_FFFF) : (va & 32'hFFF);
            pa = {e[31:8], 12'b0} + 36'(off);
            if (!e[5] || (wr && !e[6])) begin
               nwb = 1;
               leaf = e | 32'h20 | (wr ? 32'h40 : 32'h0);
            end
            return;
         end
      end
   endtask

   task automatic run(input logic [31:0] va, input bit wr, input bit en, input int ctx,
                      input logic [31:0] ctxp, input string tag);
      logic [1:0] ef, el;
      logic [31:0] eleaf, ela;
      logic [35:0] epa;
      int erd, ewb, wait_cyc;
      model(va, wr, en, ctx, ctxp, ef, el, eleaf, ela, epa, erd, ewb);
      @(negedge clk);
      rd_cnt = 0;
      wr_cnt = 0;
      req_vaddr = va; req_write = wr; ctl_enable = en;
      ctx_id = CTX_W'(ctx); ctx_table_ptr = ctxp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_cyc = 0;
      while (!done && wait_cyc < 300) begin
         @(negedge clk);
         wait_cyc++;
      end
      chk(done, {tag, " R10 done seen"}, 64'(done), 64'd1);
      chk(fault_valid == (ef != 0), {tag, " R6 fault_valid"}, 64'(fault_valid), 64'(ef != 0));
      chk(fault_code == ef, {tag, " R6 fault_code"}, 64'(fault_code), 64'(ef));
      chk(walk_level == el, {tag, " R5 level"}, 64'(walk_level), 64'(el));
      chk(leaf_entry == eleaf, {tag, " R7 leaf_entry"}, 64'(leaf_entry), 64'(eleaf));
      chk(leaf_addr == ela, {tag, " R4 leaf_addr"}, 64'(leaf_addr), 64'(ela));
      chk(phys_addr == epa, {tag, " R5 phys_addr"}, 64'(phys_addr), 64'(epa));
      chk(rd_cnt == erd, {tag, " R12 read count"}, 64'(rd_cnt), 64'(erd));
      chk(wr_cnt == ewb, {tag, " R8 write count"}, 64'(wr_cnt), 64'(ewb));
      if (ewb == 1) begin
         chk(wb_addr_seen == ela && wb_data_seen == eleaf, {tag, " R7 write-back word"},
             {wb_addr_seen, wb_data_seen}, {ela, eleaf});
         mem[wb_addr_seen[13:2]] = wb_data_seen;
      end
      @(negedge clk);
      chk(!done, {tag, " R10 single pulse"}, 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(req_ready && !done && !mem_valid, "R11 reset state",
          {61'd0, req_ready, done, mem_valid}, 64'b100);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 bypass, read and write
      run(32'hDEAD_BEEF, 1'b0, 1'b0, 3, 32'h40, "R1 bypass rd");
      run(32'h0123_4567, 1'b1, 1'b0, 5, 32'h40, "R1 bypass wr");
      // R5 leaf at table 1, clean read (R8)
      build(32'h8712_3456, 2, 32'h40, '{1, 2, -1, -1}, 3);
      run(32'h8712_3456, 1'b0, 1'b1, 2, 32'h40, "R5 16MB R8 no wb");
      // R7 write to table-2 leaf with dirty clear
      build(32'h4C9A_BCDE, 7, 32'h50, '{1, 1, 2, -1}, 1);
      run(32'h4C9A_BCDE, 1'b1, 1'b1, 7, 32'h50, "R7 256KB dirty");
      // R7 read of table-3 leaf with referenced clear
      build(32'hFFFF_F123, 15, 32'h40, '{1, 1, 1, 2}, 0);
      run(32'hFFFF_F123, 1'b0, 1'b1, 15, 32'h40, "R7 4KB ref");
      // R8 write to already-dirty table-3 leaf
      build(32'h0003_F001, 0, 32'h50, '{1, 1, 1, 2}, 3);
      run(32'h0003_F001, 1'b1, 1'b1, 0, 32'h50, "R8 4KB dirty");
      // R6 and R2 faults at each level
      build(32'h1111_1111, 4, 32'h40, '{0, -1, -1, -1}, -1);
      run(32'h1111_1111, 1'b0, 1'b1, 4, 32'h40, "R6 ctx invalid");
      build(32'h2222_2222, 4, 32'h40, '{2, -1, -1, -1}, -1);
      run(32'h2222_2222, 1'b0, 1'b1, 4, 32'h40, "R6 ctx leaf");
      build(32'h3333_3333, 9, 32'h40, '{1, 0, -1, -1}, -1);
      run(32'h3333_3333, 1'b1, 1'b1, 9, 32'h40, "R6 t1 invalid");
      build(32'h4444_4444, 9, 32'h50, '{1, 1, 3, -1}, -1);
      run(32'h4444_4444, 1'b0, 1'b1, 9, 32'h50, "R6 t2 reserved");
      build(32'h5555_5555, 1, 32'h40, '{1, 1, 1, 1}, -1);
      run(32'h5555_5555, 1'b0, 1'b1, 1, 32'h40, "R6 t3 pointer");

      // R3 R4 random walks
      for (int n = 0; n < 400; n++) begin
         logic [31:0] va = $urandom;
         int          cx = int'($urandom % 16);
         logic [31:0] cp = ($urandom % 2) ? 32'h50 : 32'h40;
         bit          w  = 1'($urandom % 2);
         bit          en = ($urandom % 16) != 0;
         build(va, cx, cp, '{-1, -1, -1, -1}, -1);
         run(va, w, en, cx, cp, "R3 random");
      end

      chk(hold_err == 0, "R9 request held while stalled", 64'(hold_err), 64'd0);
      chk(oob_cnt == 0, "R4 addresses within tables", 64'(oob_cnt), 64'd0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule